// File: doc/BRIEF.md
# Receive Status Stream Generator with Overflow Clamp

This block drives the two-bit status channel that a packet receiver returns to its transmitter. The status runs as repeating rounds. Each round opens with the framing code, carries one status code per calendar slot, and closes with a two-bit parity word. Slot k of a round reports on port k modulo the calendar length. The calendar is walked as many times as the multiplier asks.

The status per slot comes from one of two sources, chosen at build time. In fill-level mode the single shared receive buffer is graded against an almost-empty and an almost-full threshold, and every slot repeats that grade. In user mode each port's status is taken from a user-supplied array. With the clamp option on, each user code is combined with the buffer grade so that the more restrictive of the two is sent. This stops the transmitter from overrunning the shared buffer. With the clamp off, the user code goes out unchanged.

While reset or a training request is active, the channel repeats the framing code. The user array, the calendar length and the multiplier are all captured at the framing cycle, so every slot of a round is consistent.

Top module: `sg_status_gen`

## Requirements
- R1: While rst_n is low or train_req is high, stat_out is 2'b11. The first edge after train_req falls emits the framing code of a new round.
- R2: A round is one framing code 2'b11, then exactly cal_len×cal_mult slot codes, then one parity word. The next round's framing code follows at once.
- R3: Slot k of a round carries the status of port (k mod cal_len). Port p's user status sits at user_stat[2p+1:2p].
- R4: Codes are starving 2'b00, hungry 2'b01 and satisfied 2'b10. The buffer grade is taken from fill_level at the edge that launches the slot: satisfied when fill_level ≥ thr_full, else starving when fill_level < thr_empty, else hungry. In fill-level mode every slot carries this grade.
- R5: In clamped user mode, a user code of starving sends the buffer grade. A user code of hungry sends hungry, or satisfied when the buffer is satisfied. A user code of satisfied always sends satisfied.
- R6: In unclamped user mode, the user code is sent unchanged whatever the fill level.
- R7: user_stat, cal_len and cal_mult are sampled at the framing cycle only. A change during a round takes effect from the next round.
- R8: Bit j of the parity word is 1 exactly when the number of ones in bit j across that round's slot codes is even (odd parity per bit column).
- R9: A cal_len of 0 acts as 1, a cal_len above PORTS acts as PORTS, and a cal_mult of 0 acts as 1.
- R10: In user mode a user code of 2'b11 is treated as satisfied, so no slot ever carries the framing code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_req | input | 1 | Hold the channel on the framing code |
| fill_level | input | LVL_W | Current shared buffer occupancy |
| thr_empty | input | LVL_W | Almost-empty threshold |
| thr_full | input | LVL_W | Almost-full threshold |
| user_stat | input | 2×PORTS | Per-port user status, two bits per port |
| cal_len | input | LEN_W | Calendar length in ports |
| cal_mult | input | MULT_W | Calendar repetitions per round |
| stat_out | output | 2 | Status channel code |

## Verification
The assertions check the cycle-level invariants on every cycle. A training request is followed by the framing code. No slot carries the framing code. The slot count between framing and parity matches the latched length times multiplier. In clamped mode a slot is never more permissive than the buffer grade. What only the bench scenarios can show is the value content of each round. That covers the port order within the calendar, the merge table against each fill region, the parity word, the clamping of out-of-range lengths, and the rule that mid-round changes wait for the next round.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef logic [1:0] sg_code_t;

  localparam sg_code_t SG_STARVE = 2'b00;
  localparam sg_code_t SG_HUNGRY = 2'b01;
  localparam sg_code_t SG_SATED  = 2'b10;
  localparam sg_code_t SG_FRAME  = 2'b11;

  typedef enum logic [1:0] {
    PH_FRAME = 2'd0,
    PH_SLOT  = 2'd1,
    PH_DIP   = 2'd2
  } sg_phase_t;

  // A user code equal to the framing code is read as satisfied.
  function automatic sg_code_t f_clean(input sg_code_t code);
    return (code == SG_FRAME) ? SG_SATED : code;
  endfunction

  // The encoding grows with restriction, so the stricter code is the larger.
  function automatic sg_code_t f_strictest(input sg_code_t user_c, input sg_code_t buf_c);
    sg_code_t u;
    u = f_clean(user_c);
    return (u > buf_c) ? u : buf_c;
  endfunction

  // Column-wise fold of one slot into the running parity.
  function automatic sg_code_t f_dip_fold(input sg_code_t acc, input sg_code_t code);
    return acc ^ code;
  endfunction

  // Odd parity per bit column from the folded value.
  function automatic sg_code_t f_dip_final(input sg_code_t acc);
    return ~acc;
  endfunction

endpackage

// File: rtl/sg_level_class.sv
module sg_level_class
  import sg_pkg::*;
#(
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] thr_empty,
  input  logic [LVL_W-1:0] thr_full,
  output sg_code_t         buf_code
);

  function automatic sg_code_t f_grade(input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] lo,
                                       input logic [LVL_W-1:0] hi);
    if (lvl >= hi)     return SG_SATED;
    else if (lvl < lo) return SG_STARVE;
    else               return SG_HUNGRY;
  endfunction

  assign buf_code = f_grade(fill_level, thr_empty, thr_full);

  // R4: the buffer grade is always one of the three slot codes
  p_grade_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_code != SG_FRAME);

  // R4: a buffer at or above almost-full is never reported as starving
  p_full_not_starving_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level >= thr_full) |-> (buf_code != SG_STARVE));

endmodule

// File: rtl/sg_port_select.sv
module sg_port_select
  import sg_pkg::*;
#(
  parameter int PORTS      = 8,
  parameter bit USE_USER   = 1'b1,
  parameter bit SAFE_CLAMP = 1'b1,
  localparam int IDX_W     = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*PORTS-1:0] snap,
  input  logic [IDX_W-1:0]   port_idx,
  input  sg_code_t           buf_code,
  output sg_code_t           slot_code
);

  sg_code_t user_pick;

  always_comb begin
    user_pick = SG_STARVE;
    for (int p = 0; p < PORTS; p++) begin
      if (port_idx == IDX_W'(p)) user_pick = snap[2*p +: 2];
    end
  end

  generate
    if (!USE_USER) begin : g_fill
      sg_code_t unused_pick;
      assign unused_pick = user_pick;
      assign slot_code   = buf_code;
    end else if (SAFE_CLAMP) begin : g_safe
      assign slot_code = f_strictest(user_pick, buf_code);

      // R5: a clamped slot is never more permissive than the buffer grade
      p_clamp_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_code >= buf_code);

      // R5: a satisfied user request always leaves as satisfied
      p_user_sated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (user_pick == SG_SATED) |-> (slot_code == SG_SATED));
    end else begin : g_raw
      assign slot_code = f_clean(user_pick);

      // R6: unclamped slots follow the user code regardless of the buffer
      p_raw_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (user_pick != SG_FRAME) |-> (slot_code == user_pick));
    end
  endgenerate

  // R10: the selector never hands the framing code to a slot
  p_slot_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_code != SG_FRAME);

endmodule

// File: rtl/sg_sequencer.sv
module sg_sequencer
  import sg_pkg::*;
#(
  parameter int PORTS  = 8,
  parameter int LEN_W  = 4,
  parameter int MULT_W = 3,
  localparam int IDX_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int CNT_W = IDX_W + MULT_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               train_req,
  input  logic [2*PORTS-1:0] user_stat,
  input  logic [LEN_W-1:0]   cal_len,
  input  logic [MULT_W-1:0]  cal_mult,
  input  sg_code_t           slot_code,
  output logic [2*PORTS-1:0] snap,
  output logic [IDX_W-1:0]   port_idx,
  output sg_code_t           stat_out
);

  localparam logic [LEN_W-1:0] PORTS_L = LEN_W'(PORTS);

  sg_phase_t         phase;
  logic [IDX_W-1:0]  last_port;
  logic [MULT_W-1:0] rep, last_rep;
  sg_code_t          dip_acc;
  logic [LEN_W-1:0]  len_eff;
  logic [MULT_W-1:0] rep_last_c;

  // Named events for the checks
  logic round_start, slot_fire, dip_fire;
  assign round_start = (phase == PH_FRAME) && !train_req;
  assign slot_fire   = (phase == PH_SLOT)  && !train_req;
  assign dip_fire    = (phase == PH_DIP)   && !train_req;

  always_comb begin
    if (cal_len == '0)          len_eff = LEN_W'(1);
    else if (cal_len > PORTS_L) len_eff = PORTS_L;
    else                        len_eff = cal_len;
    rep_last_c = (cal_mult == '0) ? '0 : cal_mult - MULT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_FRAME;
      stat_out  <= SG_FRAME;
      snap      <= '0;
      port_idx  <= '0;
      last_port <= '0;
      rep       <= '0;
      last_rep  <= '0;
      dip_acc   <= '0;
    end else if (train_req) begin
      phase    <= PH_FRAME;
      stat_out <= SG_FRAME;
    end else begin
      case (phase)
        PH_FRAME: begin
          stat_out  <= SG_FRAME;
          snap      <= user_stat;
          last_port <= IDX_W'(len_eff - LEN_W'(1));
          last_rep  <= rep_last_c;
          port_idx  <= '0;
          rep       <= '0;
          dip_acc   <= '0;
          phase     <= PH_SLOT;
        end
        PH_SLOT: begin
          stat_out <= slot_code;
          dip_acc  <= f_dip_fold(dip_acc, slot_code);
          if (port_idx == last_port) begin
            port_idx <= '0;
            if (rep == last_rep) phase <= PH_DIP;
            else                 rep   <= rep + MULT_W'(1);
          end else begin
            port_idx <= port_idx + IDX_W'(1);
          end
        end
        default: begin
          stat_out <= f_dip_final(dip_acc);
          phase    <= PH_FRAME;
        end
      endcase
    end
  end

  // Independent slot counter for the round-length check
  logic [CNT_W-1:0] slot_cnt, exp_total;
  assign exp_total = (CNT_W'(last_port) + CNT_W'(1)) * (CNT_W'(last_rep) + CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           slot_cnt <= '0;
    else if (round_start) slot_cnt <= '0;
    else if (slot_fire)   slot_cnt <= slot_cnt + CNT_W'(1);
  end

  // R1: a training request puts the framing code on the channel next cycle
  p_train_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    train_req |=> (stat_out == SG_FRAME));

  // R2: the parity word comes after exactly length x multiplier slots
  p_slot_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dip_fire |-> (slot_cnt == exp_total));

  // R2: a framing cycle is always followed by a slot or a new training hold
  p_frame_then_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    round_start |=> (phase == PH_SLOT));

  // R10: a launched slot never shows the framing code
  p_slot_not_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fire |=> (stat_out != SG_FRAME));

  // R7: the captured user array holds still for the whole round
  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_FRAME) |=> $stable(snap));

endmodule

// File: rtl/sg_status_gen.sv
module sg_status_gen
  import sg_pkg::*;
#(
  parameter int PORTS      = 8,
  parameter int LVL_W      = 10,
  parameter int LEN_W      = 4,
  parameter int MULT_W     = 3,
  parameter bit USE_USER   = 1'b1,
  parameter bit SAFE_CLAMP = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               train_req,
  input  logic [LVL_W-1:0]   fill_level,
  input  logic [LVL_W-1:0]   thr_empty,
  input  logic [LVL_W-1:0]   thr_full,
  input  logic [2*PORTS-1:0] user_stat,
  input  logic [LEN_W-1:0]   cal_len,
  input  logic [MULT_W-1:0]  cal_mult,
  output logic [1:0]         stat_out
);

  localparam int IDX_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  sg_code_t           buf_code, slot_code, chan_code;
  logic [2*PORTS-1:0] snap;
  logic [IDX_W-1:0]   port_idx;

  sg_level_class #(.LVL_W(LVL_W)) u_class (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_level (fill_level),
    .thr_empty  (thr_empty),
    .thr_full   (thr_full),
    .buf_code   (buf_code)
  );

  sg_port_select #(
    .PORTS      (PORTS),
    .USE_USER   (USE_USER),
    .SAFE_CLAMP (SAFE_CLAMP)
  ) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap      (snap),
    .port_idx  (port_idx),
    .buf_code  (buf_code),
    .slot_code (slot_code)
  );

  sg_sequencer #(
    .PORTS  (PORTS),
    .LEN_W  (LEN_W),
    .MULT_W (MULT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .train_req (train_req),
    .user_stat (user_stat),
    .cal_len   (cal_len),
    .cal_mult  (cal_mult),
    .slot_code (slot_code),
    .snap      (snap),
    .port_idx  (port_idx),
    .stat_out  (chan_code)
  );

  assign stat_out = chan_code;

endmodule

// File: tb/sg_status_gen_tb.sv
module sg_status_gen_tb_top;

  localparam int PORTS = 8;
  localparam int LVL_W = 10;
  localparam int LEN_W = 4;
  localparam int MULT_W = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               train_req = 1'b1;
  logic [LVL_W-1:0]   fill_level = '0;
  logic [LVL_W-1:0]   thr_empty = 10'd100;
  logic [LVL_W-1:0]   thr_full = 10'd300;
  logic [2*PORTS-1:0] user_stat = '0;
  logic [LEN_W-1:0]   cal_len = 4'd4;
  logic [MULT_W-1:0]  cal_mult = 3'd1;
  logic [1:0]         out_safe, out_fill, out_raw;

  always #10 clk = ~clk;

  sg_status_gen #(.PORTS(PORTS), .LVL_W(LVL_W), .LEN_W(LEN_W), .MULT_W(MULT_W),
                  .USE_USER(1'b1), .SAFE_CLAMP(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .train_req(train_req), .fill_level(fill_level),
    .thr_empty(thr_empty), .thr_full(thr_full), .user_stat(user_stat),
    .cal_len(cal_len), .cal_mult(cal_mult), .stat_out(out_safe));

  sg_status_gen #(.PORTS(PORTS), .LVL_W(LVL_W), .LEN_W(LEN_W), .MULT_W(MULT_W),
                  .USE_USER(1'b0), .SAFE_CLAMP(1'b0)) dut_fill_i (
    .clk(clk), .rst_n(rst_n), .train_req(train_req), .fill_level(fill_level),
    .thr_empty(thr_empty), .thr_full(thr_full), .user_stat(user_stat),
    .cal_len(cal_len), .cal_mult(cal_mult), .stat_out(out_fill));

  sg_status_gen #(.PORTS(PORTS), .LVL_W(LVL_W), .LEN_W(LEN_W), .MULT_W(MULT_W),
                  .USE_USER(1'b1), .SAFE_CLAMP(1'b0)) dut_raw_i (
    .clk(clk), .rst_n(rst_n), .train_req(train_req), .fill_level(fill_level),
    .thr_empty(thr_empty), .thr_full(thr_full), .user_stat(user_stat),
    .cal_len(cal_len), .cal_mult(cal_mult), .stat_out(out_raw));

  typedef struct {
    logic [1:0] e_safe;
    logic [1:0] e_fill;
    logic [1:0] e_raw;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Bench-side models, written from the requirements
  function automatic logic [1:0] m_grade(input logic [LVL_W-1:0] lvl);
    if (lvl >= thr_full) return 2'b10;
    if (lvl < thr_empty) return 2'b00;
    return 2'b01;
  endfunction

  function automatic logic [1:0] m_safe(input logic [1:0] u, input logic [1:0] b);
    case (u)
      2'b00:   return b;
      2'b01:   return (b == 2'b10) ? 2'b10 : 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] m_raw(input logic [1:0] u);
    return (u == 2'b11) ? 2'b10 : u;
  endfunction

  // Driver: push one full round of expected codes
  task automatic push_round(input logic [2*PORTS-1:0] us, input int len, input int mult,
                            input string tag);
    int le, me;
    int ones_s[2], ones_f[2], ones_r[2];
    logic [1:0] g, cs, cf, cr;
    exp_t it;
    le = (len == 0) ? 1 : ((len > PORTS) ? PORTS : len);
    me = (mult == 0) ? 1 : mult;
    for (int b = 0; b < 2; b++) begin ones_s[b] = 0; ones_f[b] = 0; ones_r[b] = 0; end
    it.e_safe = 2'b11; it.e_fill = 2'b11; it.e_raw = 2'b11; it.tag = "R2-frame";
    exp_q.push_back(it);
    g = m_grade(fill_level);
    for (int k = 0; k < le * me; k++) begin
      int p;
      p = k % le;
      cs = m_safe(us[2*p +: 2], g);
      cf = g;
      cr = m_raw(us[2*p +: 2]);
      for (int b = 0; b < 2; b++) begin
        ones_s[b] += cs[b]; ones_f[b] += cf[b]; ones_r[b] += cr[b];
      end
      it.e_safe = cs; it.e_fill = cf; it.e_raw = cr; it.tag = tag;
      exp_q.push_back(it);
    end
    for (int b = 0; b < 2; b++) begin
      it.e_safe[b] = (ones_s[b] % 2 == 0);
      it.e_fill[b] = (ones_f[b] % 2 == 0);
      it.e_raw[b]  = (ones_r[b] % 2 == 0);
    end
    it.tag = "R8-parity";
    exp_q.push_back(it);
  endtask

  // Start a fresh round sequence: hold training one cycle, then release
  task automatic restart();
    @(negedge clk);
    train_req = 1'b1;
    @(negedge clk);
    train_req = 1'b0;
    #1;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
  endtask

  // Monitor: pop and compare once per cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        chk(out_safe == it.e_safe, it.tag, "clamped(R5)", out_safe, it.e_safe);
        chk(out_fill == it.e_fill, it.tag, "fill(R4)",    out_fill, it.e_fill);
        chk(out_raw  == it.e_raw,  it.tag, "raw(R6)",     out_raw,  it.e_raw);
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_safe == 2'b11, "R1", "reset safe", out_safe, 2'b11);
    chk(out_fill == 2'b11, "R1", "reset fill", out_fill, 2'b11);
    chk(out_raw  == 2'b11, "R1", "reset raw",  out_raw,  2'b11);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_safe == 2'b11, "R1", "training hold", out_safe, 2'b11);

    // R4/R5/R6/R10: every user code against each buffer region, full calendar
    user_stat = 16'b11_10_01_00_00_01_10_11;
    cal_len = 4'd8; cal_mult = 3'd1;
    fill_level = 10'd5;
    restart(); push_round(user_stat, 8, 1, "R5-starving-buf"); drain();
    fill_level = 10'd100;
    restart(); push_round(user_stat, 8, 1, "R4-at-empty-thr"); drain();
    fill_level = 10'd299;
    restart(); push_round(user_stat, 8, 1, "R4-below-full-thr"); drain();
    fill_level = 10'd300;
    restart(); push_round(user_stat, 8, 1, "R6-at-full-thr"); drain();
    fill_level = 10'd900;
    restart(); push_round(user_stat, 8, 1, "R10-user-frame-code"); drain();

    // R3/R2: shorter calendar with multiplier, two back-to-back rounds
    user_stat = 16'b10_10_10_10_00_10_01_00;
    cal_len = 4'd3; cal_mult = 3'd3; fill_level = 10'd150;
    restart();
    push_round(user_stat, 3, 3, "R3-order");
    push_round(user_stat, 3, 3, "R2-back-to-back");
    drain();

    // R7: change array and length mid-round; effect waits for next round
    begin
      logic [2*PORTS-1:0] old_us;
      old_us = 16'b01_00_01_00_01_00_01_00;
      user_stat = old_us; cal_len = 4'd4; cal_mult = 3'd1; fill_level = 10'd50;
      restart();
      push_round(old_us, 4, 1, "R7-old-round");
      push_round(16'b00_01_10_01_00_10_01_10, 6, 1, "R7-new-round");
      repeat (2) @(negedge clk);
      #1;
      user_stat = 16'b00_01_10_01_00_10_01_10;
      cal_len = 4'd6;
      drain();
    end

    // R9: zero length and multiplier, then an oversize length
    user_stat = 16'b01_10_00_01_10_00_01_10;
    cal_len = 4'd0; cal_mult = 3'd0; fill_level = 10'd200;
    restart(); push_round(user_stat, 0, 0, "R9-zero"); push_round(user_stat, 0, 0, "R9-zero"); drain();
    cal_len = 4'd12; cal_mult = 3'd2;
    restart(); push_round(user_stat, 12, 2, "R9-oversize"); drain();

    // R1: training in the middle of a round forces the framing code
    cal_len = 4'd8; cal_mult = 3'd4; user_stat = '0; fill_level = 10'd0;
    restart();
    repeat (4) @(negedge clk);
    chk(out_safe == 2'b00, "R1", "mid-round slot before train", out_safe, 2'b00);
    train_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_safe == 2'b11, "R1", "train hold safe", out_safe, 2'b11);
      chk(out_raw  == 2'b11, "R1", "train hold raw",  out_raw,  2'b11);
    end
    train_req = 1'b0;
    #1;
    push_round(user_stat, 8, 4, "R1-after-train");
    drain();

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule